// File: doc/BRIEF.md
# Divergence-Aware Segment Enable Generator

This block drives one enable per segment of a cache data array that serves a SIMT warp. A cache block is cut into `NUM_SEG` equal segments. Each segment holds the data of `WARP_SIZE/NUM_SEG` consecutive thread lanes. Segment `i` covers lanes `i*L` to `i*L+L-1`, where `L = WARP_SIZE/NUM_SEG`. For each access, the block switches on only the segments whose lanes are active in the mask in force. When all threads run together, that mask is the warp's live mask and the whole block is reached as usual.

A branch that splits the warp runs in two phases. The block tracks these phases and supplies the proper mask for each one:

- In the first phase, the mask is the entry mask ANDed with the taken group.
- In the second phase, the mask is the entry mask ANDed with the complement of the taken group.
- At reconvergence, the live warp mask is used again.

A phase whose mask would be empty is skipped.

Accesses enter on a valid/ready handshake. Each accepted access produces one registered result one cycle later: the segment enables, the count of enabled segments, and the read/write flag. The result is held until the consumer takes it. With a single output register, `acc_ready` is high only when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds still and no new access is accepted. The branch, phase-done and warp-mask pins are plain control inputs.

Top module: `divseg_enable`

## Requirements
- R1: After reset, `out_valid`, `seg_en`, `seg_cnt` and `div_phase` are all zero.
- R2: In a result, bit `i` of `seg_en` is 1 exactly when at least one of lanes `i*L` to `i*L+L-1` of the applied mask is 1.
- R3: While `div_phase` is 0 (converged), the applied mask is `warp_mask`, so a full `warp_mask` enables every segment.
- R4: A `br_valid` pulse in phase 0 whose `warp_mask & br_taken` is nonzero moves `div_phase` to 1 (taken). The applied mask is then the captured warp mask ANDed with `br_taken`.
- R5: A `phase_done` pulse in phase 1 moves `div_phase` to 2 (not taken) when the captured warp mask ANDed with NOT taken is nonzero. The applied mask is then that value.
- R6: A `phase_done` pulse in phase 2 returns `div_phase` to 0, and accesses use `warp_mask` again.
- R7: A phase whose mask is all zero is skipped. An empty taken group goes straight to phase 2. An empty not-taken group returns from phase 1 to 0. If both groups are empty, the phase stays at 0.
- R8: An access accepted at one clock edge appears on `out_valid`, `seg_en` and `out_write` after that edge. Its `seg_cnt` equals the number of ones in `seg_en`.
- R9: While `out_valid` is high and `out_ready` is low, `acc_ready` is low and `seg_en`, `seg_cnt` and `out_write` hold their values.
- R10: `br_valid` is ignored while `div_phase` is 1 or 2. `phase_done` is ignored in phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_mask | input | WARP_SIZE | Live active-lane mask of the warp |
| br_valid | input | 1 | Branch event pulse |
| br_taken | input | WARP_SIZE | Lanes that take the branch |
| phase_done | input | 1 | Current divergent phase has finished |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted when high with `acc_valid` |
| acc_write | input | 1 | Access is a write |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_write | output | 1 | Write flag of the result |
| seg_en | output | NUM_SEG | Per-segment enables |
| seg_cnt | output | $clog2(NUM_SEG+1) | Number of enabled segments |
| div_phase | output | 2 | 0 converged, 1 taken phase, 2 not-taken phase |

## Verification
The assertions assume the consumer follows the handshake, meaning it holds `out_ready` as a plain level. They also assume branch and phase-done events arrive as single-cycle pulses sampled at a clock edge. The bench drives every input half a period away from the rising edge. It raises `br_valid` and `phase_done` for exactly one cycle. It keeps `warp_mask` steady across a divergent branch, so the reconverged mask matches the entry mask. Back-pressure is exercised by holding `out_ready` low with a new access pending.

// File: rtl/divseg_pkg.sv
`timescale 1ns/1ps
package divseg_pkg;
  typedef enum logic [1:0] {
    PH_CONV     = 2'd0,
    PH_TAKEN    = 2'd1,
    PH_NOTTAKEN = 2'd2
  } phase_e;
endpackage

// File: rtl/divseg_reduce.sv
`timescale 1ns/1ps
module divseg_reduce #(
  parameter int WARP_SIZE = 32,
  parameter int NUM_SEG   = 8
) (
  input  logic [WARP_SIZE-1:0] lane_mask,
  output logic [NUM_SEG-1:0]   seg_any
);
  localparam int LPS = WARP_SIZE / NUM_SEG;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign seg_any[g] = |lane_mask[g*LPS +: LPS];
  end
endmodule

// File: rtl/divseg_popcnt.sv
`timescale 1ns/1ps
module divseg_popcnt #(
  parameter int NUM_SEG = 8,
  localparam int CNT_W  = $clog2(NUM_SEG + 1)
) (
  input  logic [NUM_SEG-1:0] bits_in,
  output logic [CNT_W-1:0]   count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      count = count + CNT_W'(bits_in[i]);
    end
  end
endmodule

// File: rtl/divseg_tracker.sv
`timescale 1ns/1ps
module divseg_tracker
  import divseg_pkg::*;
#(
  parameter int WARP_SIZE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WARP_SIZE-1:0] warp_mask,
  input  logic                 br_valid,
  input  logic [WARP_SIZE-1:0] br_taken,
  input  logic                 phase_done,
  output phase_e               phase,
  output logic [WARP_SIZE-1:0] cur_mask
);
  phase_e                 phase_q, phase_d;
  logic [WARP_SIZE-1:0]   entry_q, taken_q;
  logic [WARP_SIZE-1:0]   tk_grp, nt_grp;

  assign tk_grp = entry_q & taken_q;
  assign nt_grp = entry_q & ~taken_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_CONV: if (br_valid) begin
        if ((warp_mask & br_taken) != '0)       phase_d = PH_TAKEN;
        else if ((warp_mask & ~br_taken) != '0) phase_d = PH_NOTTAKEN;
      end
      PH_TAKEN: if (phase_done) begin
        phase_d = (nt_grp != '0) ? PH_NOTTAKEN : PH_CONV;
      end
      PH_NOTTAKEN: if (phase_done) phase_d = PH_CONV;
      default: phase_d = PH_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_CONV;
      entry_q <= '0;
      taken_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_CONV && br_valid) begin
        entry_q <= warp_mask;
        taken_q <= br_taken;
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_TAKEN:    cur_mask = tk_grp;
      PH_NOTTAKEN: cur_mask = nt_grp;
      default:     cur_mask = warp_mask;
    endcase
  end

  assign phase = phase_q;
endmodule

// File: rtl/divseg_enable.sv
`timescale 1ns/1ps
module divseg_enable
  import divseg_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int NUM_SEG   = 8,
  localparam int CNT_W    = $clog2(NUM_SEG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WARP_SIZE-1:0] warp_mask,
  input  logic                 br_valid,
  input  logic [WARP_SIZE-1:0] br_taken,
  input  logic                 phase_done,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_write,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_write,
  output logic [NUM_SEG-1:0]   seg_en,
  output logic [CNT_W-1:0]     seg_cnt,
  output logic [1:0]           div_phase
);
  phase_e               phase;
  logic [WARP_SIZE-1:0] cur_mask;
  logic [NUM_SEG-1:0]   seg_d;
  logic [CNT_W-1:0]     cnt_d;
  logic                 acc_fire;

  divseg_tracker #(.WARP_SIZE(WARP_SIZE)) trk_i (
    .clk(clk), .rst_n(rst_n), .warp_mask(warp_mask), .br_valid(br_valid),
    .br_taken(br_taken), .phase_done(phase_done), .phase(phase),
    .cur_mask(cur_mask)
  );

  divseg_reduce #(.WARP_SIZE(WARP_SIZE), .NUM_SEG(NUM_SEG)) red_i (
    .lane_mask(cur_mask), .seg_any(seg_d)
  );

  divseg_popcnt #(.NUM_SEG(NUM_SEG)) cnt_i (
    .bits_in(seg_d), .count(cnt_d)
  );

  assign acc_ready = !out_valid || out_ready;
  assign acc_fire  = acc_valid && acc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      seg_en    <= '0;
      seg_cnt   <= '0;
    end else if (acc_fire) begin
      out_valid <= 1'b1;
      out_write <= acc_write;
      seg_en    <= seg_d;
      seg_cnt   <= cnt_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign div_phase = phase;
endmodule

// File: rtl/divseg_chk.sv
`timescale 1ns/1ps
module divseg_chk #(
  parameter int NUM_SEG = 8,
  localparam int CNT_W  = $clog2(NUM_SEG + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               br_valid,
  input logic               phase_done,
  input logic               acc_valid,
  input logic               acc_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_write,
  input logic [NUM_SEG-1:0] seg_en,
  input logic [CNT_W-1:0]   seg_cnt,
  input logic [1:0]         div_phase
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(seg_en) &&
                                   $stable(seg_cnt) && $stable(out_write)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !acc_ready);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> out_valid);

  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seg_cnt == CNT_W'($countones(seg_en))));

  assert_phase_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_phase != 2'd3);

  assert_reconv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_phase == 2'd2 && phase_done) |=> (div_phase == 2'd0));

  assert_br_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_phase != 2'd0 && !phase_done) |=> $stable(div_phase));

  assert_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_phase == 2'd0 && !br_valid) |=> (div_phase == 2'd0));
endmodule

bind divseg_enable divseg_chk #(.NUM_SEG(NUM_SEG)) chk_i (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .phase_done(phase_done),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_write(out_write), .seg_en(seg_en),
  .seg_cnt(seg_cnt), .div_phase(div_phase)
);

// File: tb/divseg_enable_tb.sv
`timescale 1ns/1ps
module divseg_enable_tb_top;
  localparam int WS  = 32;
  localparam int NS  = 8;
  localparam int LPS = WS / NS;
  localparam int CW  = $clog2(NS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WS-1:0] warp_mask = '0;
  logic          br_valid = 1'b0;
  logic [WS-1:0] br_taken = '0;
  logic          phase_done = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic          acc_write = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_write;
  logic [NS-1:0] seg_en;
  logic [CW-1:0] seg_cnt;
  logic [1:0]    div_phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divseg_enable #(.WARP_SIZE(WS), .NUM_SEG(NS)) dut_i (.*);

  function automatic logic [NS-1:0] segs_of(input logic [WS-1:0] m);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) r[s] = |m[s*LPS +: LPS];
    return r;
  endfunction

  function automatic int ones(input logic [NS-1:0] v);
    int c = 0;
    for (int s = 0; s < NS; s++) c += int'(v[s]);
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // one access, result checked one edge later
  task automatic access(input string req, input logic wr, input logic [WS-1:0] eff);
    logic [NS-1:0] es;
    es = segs_of(eff);
    acc_valid = 1'b1; acc_write = wr;
    step();
    acc_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " seg_en"}, 64'(seg_en), 64'(es));
    check({req, " seg_cnt"}, 64'(seg_cnt), 64'(ones(es)));
    check({req, " write"}, 64'(out_write), 64'(wr));
    step();
  endtask

  task automatic pulse_br(input logic [WS-1:0] t);
    br_valid = 1'b1; br_taken = t; step(); br_valid = 1'b0;
  endtask

  task automatic pulse_done();
    phase_done = 1'b1; step(); phase_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 seg_en", 64'(seg_en), 64'd0);
    check("R1 seg_cnt", 64'(seg_cnt), 64'd0);
    check("R1 div_phase", 64'(div_phase), 64'd0);
  endtask

  task automatic t_converged();
    warp_mask = '1;
    access("R3 full", 1'b0, '1);
    warp_mask = 32'h0081_0F00;
    access("R2 sparse", 1'b1, 32'h0081_0F00);
    warp_mask = 32'h1000_0001;
    access("R2 edges", 1'b0, 32'h1000_0001);
    phase_done = 1'b1; step(); phase_done = 1'b0;
    check("R10 done in conv", 64'(div_phase), 64'd0);
  endtask

  task automatic t_diverge();
    logic [WS-1:0] e, t;
    e = 32'hFFFF_FFFF; t = 32'h0000_00F0;
    warp_mask = e;
    pulse_br(t);
    check("R4 phase", 64'(div_phase), 64'd1);
    access("R4 taken", 1'b0, e & t);
    pulse_br(32'hFFFF_FFFF);
    check("R10 br ignored", 64'(div_phase), 64'd1);
    access("R10 mask kept", 1'b1, e & t);
    pulse_done();
    check("R5 phase", 64'(div_phase), 64'd2);
    access("R5 not taken", 1'b0, e & ~t);
    pulse_done();
    check("R6 phase", 64'(div_phase), 64'd0);
    access("R6 restored", 1'b0, e);
  endtask

  task automatic t_skip();
    warp_mask = 32'h0000_FFFF;
    pulse_br(32'hFFFF_0000);
    check("R7 skip taken", 64'(div_phase), 64'd2);
    access("R7 nt mask", 1'b0, 32'h0000_FFFF);
    pulse_done();
    check("R7 back", 64'(div_phase), 64'd0);
    pulse_br(32'h0000_FFFF);
    check("R7 taken only", 64'(div_phase), 64'd1);
    pulse_done();
    check("R7 skip nt", 64'(div_phase), 64'd0);
    warp_mask = '0;
    pulse_br(32'h00FF_00FF);
    check("R7 both empty", 64'(div_phase), 64'd0);
  endtask

  task automatic t_backpressure();
    warp_mask = 32'h0000_000F;
    out_ready = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b1;
    step();
    warp_mask = 32'hFFFF_0000; acc_write = 1'b0;
    check("R9 acc_ready low", 64'(acc_ready), 64'd0);
    step(); step();
    check("R9 held seg", 64'(seg_en), 64'(segs_of(32'h0000_000F)));
    check("R9 held write", 64'(out_write), 64'd1);
    out_ready = 1'b1;
    step();
    acc_valid = 1'b0;
    check("R8 next result", 64'(seg_en), 64'(segs_of(32'hFFFF_0000)));
    check("R8 next cnt", 64'(seg_cnt), 64'd4);
    step();
    check("R8 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_converged();
    t_diverge();
    t_skip();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule